// File: doc/BRIEF.md
# Oversampling Result Accumulator

This block sits between a successive-approximation conversion core and the result register of a scanned multi-channel converter. For each channel in the scan it sums N raw 12-bit codes. It then divides the sum by a power of two with rounding, and it presents a right-aligned 16-bit oversampled value. The block also requests each raw conversion from the core. It can do this back to back, one channel per trigger, or one raw conversion per trigger, so that an external trigger rate sets the oversampling rate.

The status pulses are decimated. The sampling-done pulse follows every raw sample. The result pulse follows every N-th raw result of a channel. The sequence pulse follows the final channel's result. Each finished result is checked against a window on its upper twelve bits. An overrun pulse marks a result that replaced one the consumer had not yet acknowledged. A stop request discards a partial sum at once.

Top module: `ovs_accum`

## Requirements
- R1: While `rst_n` is low, and for two clock cycles after it rises, every output is zero.
- R2: `eosmp` is high in the cycle after each cycle with `smp_done` high, whatever the run state.
- R3: The ratio is N = 2^(`cfg_ratio_sel`+1), giving 2 to 256. One cycle after the N-th accepted `raw_valid` of a channel, `eoc` pulses for one cycle and `res_chan` holds the channel index, counted from 0. `raw_valid` is accepted only while a conversion is outstanding.
- R4: `res_data` = min(65535, (S + H) >> k), where S is the channel sum and k = min(`cfg_shift`, 8). H = 2^(k-1), or 0 when k = 0. The result is always right-aligned. `res_data` and `res_chan` hold their value until the next result.
- R5: Before summing, `raw_code` is masked to 12, 10, 8 or 6 low bits for `cfg_res` = 0, 1, 2 or 3. Masked codes are then summed, rounded and shifted exactly as full codes are.
- R6: `eoseq` pulses together with the `eoc` of channel `cfg_seq_last`. After that pulse the block is idle.
- R7: `conv_start` is a one-cycle request. A `trig` while idle requests the first conversion of channel 0 one cycle later.
  - With `cfg_trig_mode`=0 and `cfg_disc`=0, every accepted raw result is followed one cycle later by the next request, until the sequence is done.
  - With `cfg_disc`=1, the block waits for a new `trig` after each channel's result.
  - With `cfg_trig_mode`=1, the block waits for a `trig` after every raw result, whatever the value of `cfg_disc`.
  - A `trig` while a conversion is outstanding is ignored.
- R8: `stop` has priority over all other inputs. It discards the partial sum, the sample count and the channel position. It produces no `eoc` and no `conv_start` in the next cycle. The next `trig` restarts the run at channel 0 with an empty sum.
- R9: `ovr` pulses together with an `eoc` when an earlier result has not been acknowledged by `rd_ack` since it appeared. An `rd_ack` in the same cycle as the new result's final sample counts as reading the old result first.
- R10: `wd_alert` pulses with `eoc` when `cfg_wd_en` is set, the channel matches `cfg_wd_chan` (only if `cfg_wd_single` is set), and `res_data[15:4]` is above `cfg_wd_hi` or below `cfg_wd_lo`. `cfg_res` does not affect this comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Start / continue trigger |
| stop | input | 1 | Abort the run and discard the partial sum |
| smp_done | input | 1 | Core finished a sampling phase |
| raw_valid | input | 1 | Core delivers a raw code |
| raw_code | input | 12 | Raw conversion code |
| rd_ack | input | 1 | Consumer has read the current result |
| cfg_ratio_sel | input | 3 | Ratio select, N = 2^(sel+1) |
| cfg_shift | input | 4 | Right shift, clamped to 8 |
| cfg_res | input | 2 | Raw resolution: 12/10/8/6 bits |
| cfg_disc | input | 1 | One channel per trigger |
| cfg_trig_mode | input | 1 | One raw conversion per trigger |
| cfg_seq_last | input | 4 | Index of the last channel in the scan |
| cfg_wd_en | input | 1 | Window check enable |
| cfg_wd_single | input | 1 | Window check on one channel only |
| cfg_wd_chan | input | 4 | Channel for single-channel window check |
| cfg_wd_hi | input | 12 | Window upper limit |
| cfg_wd_lo | input | 12 | Window lower limit |
| conv_start | output | 1 | Request one raw conversion |
| eosmp | output | 1 | Sampling-done pulse |
| eoc | output | 1 | Oversampled result ready pulse |
| eoseq | output | 1 | Sequence complete pulse |
| ovr | output | 1 | Unread result overwritten pulse |
| wd_alert | output | 1 | Result outside the window |
| res_data | output | 16 | Oversampled result |
| res_chan | output | 4 | Channel of `res_data` |

## Verification
A wrong sample count or a stale partial sum shows up one cycle after the next N-th raw result, as an `eoc` in the wrong cycle or a wrong `res_data`. A wrong channel position shows up at the same time in `res_chan` and `eoseq`. A run-state error appears sooner, as a missing or extra `conv_start` one cycle after the offending `raw_valid` or `trig`. A wrong read-pending state surfaces only at the following result, as a wrong `ovr`.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

  // run state of the conversion sequencer
  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,   // no sequence in progress
    RUN_BUSY = 2'd1,   // one raw conversion outstanding
    RUN_HOLD = 2'd2    // waiting for a trigger to continue
  } run_e;

endpackage

// File: rtl/ovs_seq.sv
module ovs_seq
  import ovs_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             stop,
  input  logic             raw_valid,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic [CH_W-1:0]  seq_last,
  input  logic             disc,
  input  logic             trig_mode,
  output logic             take,
  output logic             hit_n,
  output logic             hit_seq,
  output logic [CH_W-1:0]  chan,
  output logic             conv_start
);

  logic [CNT_W:0]   ratio_full;
  logic [CNT_W:0]   ratio_m1;
  run_e             st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CH_W-1:0]  chan_q, chan_nxt;
  logic             start_q, start_nxt;
  logic             seq_en;

  assign ratio_full = {{(CNT_W-1){1'b0}}, 2'b10} << ratio_sel;
  assign ratio_m1   = ratio_full - {{CNT_W{1'b0}}, 1'b1};

  assign take    = raw_valid && (st_q == RUN_BUSY) && !stop;
  assign hit_n   = take && ({1'b0, cnt_q} == ratio_m1);
  assign hit_seq = hit_n && (chan_q == seq_last);
  assign seq_en  = stop | trig | raw_valid;

  always_comb begin
    st_nxt    = st_q;
    cnt_nxt   = cnt_q;
    chan_nxt  = chan_q;
    start_nxt = 1'b0;
    if (stop) begin
      st_nxt   = RUN_IDLE;
      cnt_nxt  = '0;
      chan_nxt = '0;
    end else begin
      unique case (st_q)
        RUN_IDLE: begin
          if (trig) begin
            st_nxt    = RUN_BUSY;
            start_nxt = 1'b1;
            cnt_nxt   = '0;
            chan_nxt  = '0;
          end
        end
        RUN_BUSY: begin
          if (take) begin
            cnt_nxt = hit_n ? '0 : cnt_q + 1'b1;
            if (hit_n) chan_nxt = hit_seq ? '0 : chan_q + 1'b1;
            if (hit_seq)                        st_nxt = RUN_IDLE;
            else if (trig_mode || (disc && hit_n)) st_nxt = RUN_HOLD;
            else                                start_nxt = 1'b1;
          end
        end
        RUN_HOLD: begin
          if (trig) begin
            st_nxt    = RUN_BUSY;
            start_nxt = 1'b1;
          end
        end
        default: st_nxt = RUN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RUN_IDLE;
      cnt_q  <= '0;
      chan_q <= '0;
    end else if (seq_en) begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      chan_q <= chan_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_nxt;
  end

  assign chan       = chan_q;
  assign conv_start = start_q;

endmodule

// File: rtl/ovs_round.sv
module ovs_round #(
  parameter int ACC_W     = 20,
  parameter int OUT_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int SHIFT_MAX = 8
) (
  input  logic [ACC_W-1:0]   sum,
  input  logic [SHIFT_W-1:0] shift,
  output logic [OUT_W-1:0]   res
);

  logic [SHIFT_W-1:0] k;
  logic [ACC_W:0]     half;
  logic [ACC_W:0]     rnd;
  logic [ACC_W:0]     shifted;

  always_comb begin
    k = (shift > SHIFT_W'(SHIFT_MAX)) ? SHIFT_W'(SHIFT_MAX) : shift;
    if (k == '0) half = '0;
    else         half = {{ACC_W{1'b0}}, 1'b1} << (k - 1'b1);
    rnd     = {1'b0, sum} + half;
    shifted = rnd >> k;
    if (|shifted[ACC_W:OUT_W]) res = '1;
    else                       res = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/ovs_window.sv
module ovs_window #(
  parameter int RAW_W = 12,
  parameter int CH_W  = 4
) (
  input  logic [RAW_W-1:0] cmp_val,
  input  logic [CH_W-1:0]  chan,
  input  logic             en,
  input  logic             single,
  input  logic [CH_W-1:0]  sel_chan,
  input  logic [RAW_W-1:0] hi,
  input  logic [RAW_W-1:0] lo,
  output logic             outside
);

  logic chan_ok;

  assign chan_ok = !single || (chan == sel_chan);
  assign outside = en && chan_ok && ((cmp_val > hi) || (cmp_val < lo));

endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int RAW_W     = 12,
  parameter int OUT_W     = 16,
  parameter int SEL_W     = 3,
  parameter int SHIFT_W   = 4,
  parameter int SHIFT_MAX = 8,
  parameter int CH_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic               stop,
  input  logic               smp_done,
  input  logic               raw_valid,
  input  logic [RAW_W-1:0]   raw_code,
  input  logic               rd_ack,
  input  logic [SEL_W-1:0]   cfg_ratio_sel,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [1:0]         cfg_res,
  input  logic               cfg_disc,
  input  logic               cfg_trig_mode,
  input  logic [CH_W-1:0]    cfg_seq_last,
  input  logic               cfg_wd_en,
  input  logic               cfg_wd_single,
  input  logic [CH_W-1:0]    cfg_wd_chan,
  input  logic [RAW_W-1:0]   cfg_wd_hi,
  input  logic [RAW_W-1:0]   cfg_wd_lo,
  output logic               conv_start,
  output logic               eosmp,
  output logic               eoc,
  output logic               eoseq,
  output logic               ovr,
  output logic               wd_alert,
  output logic [OUT_W-1:0]   res_data,
  output logic [CH_W-1:0]    res_chan
);

  localparam int CNT_W = 1 << SEL_W;
  localparam int ACC_W = RAW_W + CNT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // sequencing
  logic            take, hit_n, hit_seq;
  logic [CH_W-1:0] chan;

  ovs_seq #(
    .SEL_W (SEL_W),
    .CNT_W (CNT_W),
    .CH_W  (CH_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trig       (trig),
    .stop       (stop),
    .raw_valid  (raw_valid),
    .ratio_sel  (cfg_ratio_sel),
    .seq_last   (cfg_seq_last),
    .disc       (cfg_disc),
    .trig_mode  (cfg_trig_mode),
    .take       (take),
    .hit_n      (hit_n),
    .hit_seq    (hit_seq),
    .chan       (chan),
    .conv_start (conv_start)
  );

  // resolution mask and running sum
  logic [RAW_W-1:0] res_mask;
  logic [RAW_W-1:0] code_m;
  logic [ACC_W-1:0] acc_q, acc_nxt, sum;
  logic             acc_en;

  assign res_mask = {RAW_W{1'b1}} >> {cfg_res, 1'b0};
  assign code_m   = raw_code & res_mask;
  assign sum      = acc_q + {{CNT_W{1'b0}}, code_m};
  assign acc_en   = stop | take;

  always_comb begin
    if (stop)       acc_nxt = '0;
    else if (hit_n) acc_nxt = '0;
    else            acc_nxt = sum;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  acc_q <= '0;
    else if (acc_en) acc_q <= acc_nxt;
  end

  // rounding, shifting, saturation
  logic [OUT_W-1:0] rounded;

  ovs_round #(
    .ACC_W     (ACC_W),
    .OUT_W     (OUT_W),
    .SHIFT_W   (SHIFT_W),
    .SHIFT_MAX (SHIFT_MAX)
  ) u_round (
    .sum   (sum),
    .shift (cfg_shift),
    .res   (rounded)
  );

  // window check on the upper bits of the result
  logic outside;

  ovs_window #(
    .RAW_W (RAW_W),
    .CH_W  (CH_W)
  ) u_win (
    .cmp_val  (rounded[OUT_W-1 -: RAW_W]),
    .chan     (chan),
    .en       (cfg_wd_en),
    .single   (cfg_wd_single),
    .sel_chan (cfg_wd_chan),
    .hi       (cfg_wd_hi),
    .lo       (cfg_wd_lo),
    .outside  (outside)
  );

  // result register and status pulses
  logic pend_q, pend_nxt, ovr_nxt;

  assign pend_nxt = hit_n | (pend_q & ~rd_ack);
  assign ovr_nxt  = hit_n & pend_q & ~rd_ack;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_data <= '0;
      res_chan <= '0;
    end else if (hit_n) begin
      res_data <= rounded;
      res_chan <= chan;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      eosmp    <= 1'b0;
      eoc      <= 1'b0;
      eoseq    <= 1'b0;
      ovr      <= 1'b0;
      wd_alert <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      eosmp    <= smp_done;
      eoc      <= hit_n;
      eoseq    <= hit_seq;
      ovr      <= ovr_nxt;
      wd_alert <= hit_n & outside;
      pend_q   <= pend_nxt;
    end
  end

endmodule

// File: rtl/ovs_accum_chk.sv
module ovs_accum_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_done,
  input logic raw_valid,
  input logic stop,
  input logic conv_start,
  input logic eosmp,
  input logic eoc,
  input logic eoseq,
  input logic ovr,
  input logic wd_alert
);

  // becomes true once the block's internal reset has been released
  logic [1:0] live_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end
  assign armed = (live_cnt == 2'd3);

  p_smp_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (eosmp == $past(smp_done)));

  p_eoc_after_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && eoc) |-> $past(raw_valid));

  p_seq_with_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoseq |-> eoc);

  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(stop)) |-> (!eoc && !conv_start));

  p_ovr_with_eoc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> eoc);

  p_alert_with_eoc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_alert |-> eoc);

endmodule

bind ovs_accum ovs_accum_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_done   (smp_done),
  .raw_valid  (raw_valid),
  .stop       (stop),
  .conv_start (conv_start),
  .eosmp      (eosmp),
  .eoc        (eoc),
  .eoseq      (eoseq),
  .ovr        (ovr),
  .wd_alert   (wd_alert)
);

// File: tb/sim_ovs_accum.sv
module sim_ovs_accum;

  logic        clk;
  logic        rst_n;
  logic        trig, stop, smp_done, raw_valid, rd_ack;
  logic [11:0] raw_code;
  logic [2:0]  cfg_ratio_sel;
  logic [3:0]  cfg_shift;
  logic [1:0]  cfg_res;
  logic        cfg_disc, cfg_trig_mode;
  logic [3:0]  cfg_seq_last;
  logic        cfg_wd_en, cfg_wd_single;
  logic [3:0]  cfg_wd_chan;
  logic [11:0] cfg_wd_hi, cfg_wd_lo;
  logic        conv_start, eosmp, eoc, eoseq, ovr, wd_alert;
  logic [15:0] res_data;
  logic [3:0]  res_chan;

  ovs_accum u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .stop(stop), .smp_done(smp_done),
    .raw_valid(raw_valid), .raw_code(raw_code), .rd_ack(rd_ack),
    .cfg_ratio_sel(cfg_ratio_sel), .cfg_shift(cfg_shift), .cfg_res(cfg_res),
    .cfg_disc(cfg_disc), .cfg_trig_mode(cfg_trig_mode), .cfg_seq_last(cfg_seq_last),
    .cfg_wd_en(cfg_wd_en), .cfg_wd_single(cfg_wd_single), .cfg_wd_chan(cfg_wd_chan),
    .cfg_wd_hi(cfg_wd_hi), .cfg_wd_lo(cfg_wd_lo),
    .conv_start(conv_start), .eosmp(eosmp), .eoc(eoc), .eoseq(eoseq), .ovr(ovr),
    .wd_alert(wd_alert), .res_data(res_data), .res_chan(res_chan)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc   = 0;
  string tag   = "R3";
  bit    done  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0, m_cnt = 0, m_chan = 0, m_acc = 0, m_hold = 0;
  bit m_pend = 0;
  int e_res = 0, e_chan = 0;
  bit e_eosmp = 0, e_eoc = 0, e_eoseq = 0, e_ovr = 0, e_wd = 0, e_start = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 2; m_st = 0; m_cnt = 0; m_chan = 0; m_acc = 0; m_pend = 0;
      e_res = 0; e_chan = 0; e_eosmp = 0; e_eoc = 0; e_eoseq = 0;
      e_ovr = 0; e_wd = 0; e_start = 0;
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      int n, k, r, v, top;
      bit fin;
      n = 2 << cfg_ratio_sel;
      k = (cfg_shift > 8) ? 8 : int'(cfg_shift);
      e_eosmp = smp_done;
      e_eoc = 0; e_eoseq = 0; e_ovr = 0; e_wd = 0; e_start = 0;
      fin = 0;
      if (stop) begin
        m_st = 0; m_cnt = 0; m_chan = 0; m_acc = 0;
      end else if (m_st == 0) begin
        if (trig) begin m_st = 1; e_start = 1; m_cnt = 0; m_chan = 0; m_acc = 0; end
      end else if (m_st == 1) begin
        if (raw_valid) begin
          v = int'(raw_code) & (4095 >> (2 * cfg_res));
          m_acc += v;
          m_cnt++;
          if (m_cnt == n) begin
            fin = 1;
            r = (k == 0) ? m_acc : ((m_acc + (1 << (k - 1))) >> k);
            if (r > 65535) r = 65535;
            e_res = r; e_chan = m_chan; e_eoc = 1;
            top = r >> 4;
            e_wd = cfg_wd_en && (!cfg_wd_single || m_chan == int'(cfg_wd_chan)) &&
                   (top > int'(cfg_wd_hi) || top < int'(cfg_wd_lo));
            m_acc = 0; m_cnt = 0;
            if (m_chan == int'(cfg_seq_last)) begin e_eoseq = 1; m_st = 0; m_chan = 0; end
            else m_chan++;
          end
          if (m_st == 1) begin
            if (cfg_trig_mode || (cfg_disc && fin)) m_st = 2;
            else e_start = 1;
          end
        end
      end else begin
        if (trig) begin m_st = 1; e_start = 1; end
      end
      if (e_eoc) begin e_ovr = m_pend && !rd_ack; m_pend = 1; end
      else if (rd_ack) m_pend = 0;
    end
  end

  // ---------------- conversion core model and comparison ----------------
  int          cd = 0;
  int unsigned seed = 32'h1234_5678;
  bit          code_max = 0;
  bit          code_hi  = 0;

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n || m_hold > 0) begin
        chk("R1", "reset conv_start", conv_start, 0);
        chk("R1", "reset eoc", eoc, 0);
        chk("R1", "reset res_data", res_data, 0);
        chk("R1", "reset flags", {eosmp, eoseq, ovr, wd_alert}, 0);
      end else begin
        chk("R2", "eosmp", eosmp, e_eosmp);
        chk({tag, "/R3"}, "eoc", eoc, e_eoc);
        chk({tag, "/R4"}, "res_data", res_data, e_res);
        chk("R3", "res_chan", res_chan, e_chan);
        chk("R6", "eoseq", eoseq, e_eoseq);
        chk({tag, "/R7"}, "conv_start", conv_start, e_start);
        chk("R9", "ovr", ovr, e_ovr);
        chk("R10", "wd_alert", wd_alert, e_wd);
      end
    end
    smp_done  <= 1'b0;
    raw_valid <= 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 1) smp_done <= 1'b1;
      if (cd == 0) begin
        raw_valid <= 1'b1;
        seed = seed * 32'd1103515245 + 32'd12345;
        if (code_max)     raw_code <= 12'hFFF;
        else if (code_hi) raw_code <= {4'hF, seed[15:8]};
        else              raw_code <= seed[19:8];
      end
    end
    if (conv_start) cd = 3;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog timeout act=%0d exp=%0d", cyc, 60000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; trig = 1'b0; stop = 1'b0; rd_ack = 1'b1;
    smp_done = 1'b0; raw_valid = 1'b0; raw_code = '0;
    cfg_ratio_sel = 3'd1; cfg_shift = 4'd0; cfg_res = 2'd0;
    cfg_disc = 1'b0; cfg_trig_mode = 1'b0; cfg_seq_last = 4'd2;
    cfg_wd_en = 1'b1; cfg_wd_single = 1'b0; cfg_wd_chan = 4'd0;
    cfg_wd_hi = 12'h300; cfg_wd_lo = 12'h100;
    idle(5);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // continuous scan, N=4, no shift; second trigger mid-run is ignored (R7)
    tag = "R7";
    pulse_trig();
    idle(6);
    pulse_trig();
    idle(80);

    // N=256 full-scale codes, no shift: saturation (R4)
    tag = "R4";
    cfg_ratio_sel = 3'd7; cfg_shift = 4'd0; cfg_seq_last = 4'd0; code_max = 1;
    pulse_trig();
    idle(1100);
    code_max = 0;

    // N=16, shift request above 8 clamps to 8; 8-bit codes with junk above (R5); unread results (R9)
    tag = "R5";
    cfg_ratio_sel = 3'd3; cfg_shift = 4'd12; cfg_res = 2'd2; cfg_seq_last = 4'd1;
    code_hi = 1; rd_ack = 1'b0;
    pulse_trig();
    idle(160);
    rd_ack = 1'b1; code_hi = 0; cfg_res = 2'd1; cfg_shift = 4'd3;
    pulse_trig();
    idle(160);
    cfg_res = 2'd0;

    // one channel per trigger, N=2, shift 1, window on channel 1 only (R10)
    tag = "R10";
    cfg_disc = 1'b1; cfg_ratio_sel = 3'd0; cfg_shift = 4'd1; cfg_seq_last = 4'd2;
    cfg_wd_single = 1'b1; cfg_wd_chan = 4'd1; cfg_wd_hi = 12'h400; cfg_wd_lo = 12'h200;
    for (int i = 0; i < 3; i++) begin pulse_trig(); idle(30); end

    // one raw conversion per trigger, disc ignored; N=4, two channels (R7)
    tag = "R7";
    cfg_trig_mode = 1'b1; cfg_disc = 1'b0; cfg_ratio_sel = 3'd1; cfg_seq_last = 4'd1;
    cfg_wd_single = 1'b0; cfg_shift = 4'd2;
    for (int i = 0; i < 8; i++) begin pulse_trig(); idle(10); end
    cfg_trig_mode = 1'b0;

    // abort mid-accumulation, then restart from channel 0 (R8)
    tag = "R8";
    cfg_ratio_sel = 3'd2; cfg_shift = 4'd1; cfg_seq_last = 4'd1;
    pulse_trig();
    idle(15);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    idle(30);
    @(negedge clk); stop = 1'b1; trig = 1'b1;
    @(negedge clk); stop = 1'b0; trig = 1'b0;
    idle(10);
    pulse_trig();
    idle(100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule